// File: doc/BRIEF.md
# Bus GPIO Register Controller

A memory-mapped general-purpose I/O controller that serves between 1 and 32 pad lines from a single-word bus slave port. Software drives the pads through an output-data register and an output-enable register. A per-line source select can hand any pad output over to an auxiliary input instead of the data register. Pad inputs pass through a two-flop synchronizer before they are read or examined for edges. Wider systems instantiate the block several times.

Each line can raise an interrupt on a rising or falling edge of its synchronized input. Captured events collect in a per-line status register and in a pending flag in the control word. One interrupt request line is asserted while both the pending flag and the global enable are set. The controller also holds two per-line select words for a separate external-clock sampling block and drives them out unchanged.

The bus port answers every accepted request one clock later with a registered acknowledge or error and with registered read data. A parameter selects full or partial address decoding. A second parameter selects strict-word mode, in which any sub-word access is refused with the error signal. Outside strict-word mode, the byte selects gate writes lane by lane.

Top module: `pio_ctrl`

## Requirements
- R1: After reset, every writable register, `pad_out`, `pad_oe`, `extclk_sel`, `extclk_negedge`, `irq`, `bus_ack` and `bus_err` are zero.
- R2: The registers at byte offsets 0x04 (output data), 0x08 (output enable), 0x0C (interrupt enable), 0x10 (edge polarity), 0x14 (auxiliary select), 0x20 (external-clock select) and 0x24 (clock-edge select) read back what was written. Bits at and above LINES read as zero. `extclk_sel` and `extclk_negedge` mirror the registers at 0x20 and 0x24. A request accepted on one rising edge is answered with `bus_ack` and read data after that edge.
- R3: Offset 0x00 returns the pad inputs delayed by two system-clock flops. A read accepted on the first edge after a pad change still returns the old value. Writes to 0x00 change nothing.
- R4: Line i of `pad_out` is `aux_in[i]` when auxiliary-select bit i is 1, and output-data bit i otherwise. `pad_oe` equals the output-enable register. Both outputs are registered one clock behind their sources.
- R5: With STRICT_WORD=0, bit k of `bus_sel` enables writing data bits 8k+7..8k. Unselected lanes keep their value.
- R6: With STRICT_WORD=1, an access whose `bus_sel` is not 4'hF completes with `bus_err` instead of `bus_ack` and writes nothing. `bus_ack` and `bus_err` are never high together.
- R7: With FULL_DECODE=1, an access with address bits 7:6 or 1:0 nonzero reads zero and writes nothing. With FULL_DECODE=0, only bits 5:2 pick the register, so such addresses alias.
- R8: Offsets 0x28 to 0x3C read as zero.
- R9: When interrupt-enable bit i is 1 and synchronized input i shows an edge of the polarity chosen by bit i of 0x10 (1 = rising, 0 = falling), status bit i at 0x1C and control bit 1 at 0x18 are set. Edges on lines whose enable bit is 0 set nothing. `irq` is high exactly while control bits 0 and 1 are both 1.
- R10: Writing 0 to a status bit or to control bit 1 clears it, unless a new event arrives in the same cycle, in which case the event is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADDR_W | Byte address |
| bus_sel | input | 4 | Byte-lane selects |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Registered read data |
| bus_ack | output | 1 | Request completed |
| bus_err | output | 1 | Request refused (sub-word access in strict-word mode) |
| pad_in | input | LINES | Pad inputs, asynchronous |
| aux_in | input | LINES | Auxiliary output sources |
| pad_out | output | LINES | Registered pad output values |
| pad_oe | output | LINES | Registered pad output enables |
| extclk_sel | output | LINES | Per-line external-clock select for the sampling block |
| extclk_negedge | output | LINES | Per-line clock-edge select for the sampling block |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is an interrupt on one line that is kept apart from edges of the opposite polarity on another enabled line. Reaching it needs the pads first parked at a known level, then mixed polarity bits, and then edges applied one at a time with enough settling cycles for the synchronizer. The bench places polarity bits on some enabled lines and not on others, and moves single pad bits up and down between reads of the status word. This shows that only matching edges are captured, that a rising edge on a falling-polarity line is ignored, and that clearing by write and re-arming work. Decode aliasing and strict-word refusal are observed by driving one bus into two instances with different parameter choices.

// File: rtl/pio_pkg.sv
package pio_pkg;

   localparam int unsigned BUS_W   = 32;
   localparam int unsigned LANES   = BUS_W / 8;

   // register index = byte address bits 5:2
   localparam logic [3:0] IDX_PADIN  = 4'd0;
   localparam logic [3:0] IDX_DOUT   = 4'd1;
   localparam logic [3:0] IDX_DOE    = 4'd2;
   localparam logic [3:0] IDX_IEN    = 4'd3;
   localparam logic [3:0] IDX_POL    = 4'd4;
   localparam logic [3:0] IDX_AUXSEL = 4'd5;
   localparam logic [3:0] IDX_CTRL   = 4'd6;
   localparam logic [3:0] IDX_STAT   = 4'd7;
   localparam logic [3:0] IDX_CKSEL  = 4'd8;
   localparam logic [3:0] IDX_CKNEG  = 4'd9;

   // control word bit positions
   localparam int unsigned CTRL_GLB_EN  = 0;
   localparam int unsigned CTRL_PENDING = 1;

   // merge new data into old data on the lanes that are enabled
   function automatic logic [BUS_W-1:0] lane_merge(
      input logic [BUS_W-1:0] old_w,
      input logic [BUS_W-1:0] new_w,
      input logic [LANES-1:0] lane_en);
      logic [BUS_W-1:0] r;
      for (int b = 0; b < BUS_W; b++) begin
         r[b] = lane_en[b/8] ? new_w[b] : old_w[b];
      end
      return r;
   endfunction

endpackage

// File: rtl/pio_bus_slave.sv
module pio_bus_slave #(
   parameter int unsigned ADDR_W      = 8,
   parameter bit          FULL_DECODE = 1'b1,
   parameter bit          STRICT_WORD = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_cyc,
   input  logic                          bus_stb,
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_adr,
   input  logic [pio_pkg::LANES-1:0]     bus_sel,
   input  logic [pio_pkg::BUS_W-1:0]     rd_word,
   output logic [3:0]                    reg_idx,
   output logic                          wr_stb,
   output logic [pio_pkg::LANES-1:0]     lane_en,
   output logic [pio_pkg::BUS_W-1:0]     bus_rdat,
   output logic                          bus_ack,
   output logic                          bus_err
);
   import pio_pkg::*;

   localparam logic [LANES-1:0] ALL_LANES = '1;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("pio_bus_slave: ADDR_W must be at least 8");
   end

   logic accept;
   logic size_bad;
   logic addr_ok;
   logic ack_q, err_q;
   logic [BUS_W-1:0] rdat_q;

   assign accept  = bus_cyc && bus_stb && !ack_q && !err_q;
   assign reg_idx = bus_adr[5:2];

   if (STRICT_WORD) begin : g_strict
      assign size_bad = (bus_sel != ALL_LANES);
   end else begin : g_lanes
      assign size_bad = 1'b0;
   end

   if (FULL_DECODE) begin : g_full
      assign addr_ok = (bus_adr[ADDR_W-1:6] == '0) && (bus_adr[1:0] == 2'b00);
   end else begin : g_partial
      assign addr_ok = 1'b1;
   end

   assign wr_stb  = accept && bus_we && !size_bad && addr_ok;
   assign lane_en = bus_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         err_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         ack_q <= accept && !size_bad;
         err_q <= accept && size_bad;
         if (accept) begin
            rdat_q <= (addr_ok && !size_bad && !bus_we) ? rd_word : '0;
         end
      end
   end

   assign bus_ack  = ack_q;
   assign bus_err  = err_q;
   assign bus_rdat = rdat_q;

   assert_one_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ack && bus_err));

   assert_resp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack || bus_err) |-> $past(bus_cyc && bus_stb));

   if (STRICT_WORD) begin : g_strict_chk
      assert_subword_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cyc && bus_stb && !bus_ack && !bus_err && bus_sel != ALL_LANES)
         |=> (bus_err && !bus_ack));
   end

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
   parameter int unsigned LINES = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pad_in,
   input  logic [LINES-1:0] int_en,
   input  logic [LINES-1:0] rise_sel,
   output logic [LINES-1:0] pad_sync,
   output logic [LINES-1:0] edge_evt
);
   logic [LINES-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= pad_in;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic went_up, went_down;
      assign went_up     = sync_q[i] && !prev_q[i];
      assign went_down   = !sync_q[i] && prev_q[i];
      assign edge_evt[i] = int_en[i] && (rise_sel[i] ? went_up : went_down);
   end

   assign pad_sync = sync_q;

   assert_sync_two_flops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |=> (prev_q == $past(sync_q)));

endmodule

// File: rtl/pio_out_drive.sv
module pio_out_drive #(
   parameter int unsigned LINES = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] dout_reg,
   input  logic [LINES-1:0] doe_reg,
   input  logic [LINES-1:0] aux_sel,
   input  logic [LINES-1:0] aux_in,
   output logic [LINES-1:0] pad_out,
   output logic [LINES-1:0] pad_oe
);
   logic [LINES-1:0] src;
   logic [LINES-1:0] out_q, oe_q;

   for (genvar i = 0; i < LINES; i++) begin : g_mux
      assign src[i] = aux_sel[i] ? aux_in[i] : dout_reg[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= '0;
      end else begin
         out_q <= src;
         oe_q  <= doe_reg;
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = oe_q;

   assert_oe_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pad_oe == $past(doe_reg)));

   assert_data_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(aux_sel) == '0) |-> (pad_out == $past(dout_reg)));

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl #(
   parameter int unsigned LINES       = 24,
   parameter int unsigned ADDR_W      = 8,
   parameter bit          FULL_DECODE = 1'b1,
   parameter bit          STRICT_WORD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_adr,
   input  logic [3:0]        bus_sel,
   input  logic [31:0]       bus_wdat,
   output logic [31:0]       bus_rdat,
   output logic              bus_ack,
   output logic              bus_err,
   input  logic [LINES-1:0]  pad_in,
   input  logic [LINES-1:0]  aux_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   output logic [LINES-1:0]  extclk_sel,
   output logic [LINES-1:0]  extclk_negedge,
   output logic              irq
);
   import pio_pkg::*;

   // the plain read/write registers and their map indices
   localparam int unsigned NPLAIN = 7;
   localparam logic [3:0] PLAIN_IDX [NPLAIN] =
      '{IDX_DOUT, IDX_DOE, IDX_IEN, IDX_POL, IDX_AUXSEL, IDX_CKSEL, IDX_CKNEG};
   localparam int unsigned P_DOUT = 0, P_DOE = 1, P_IEN = 2, P_POL = 3,
                           P_AUX = 4, P_CKSEL = 5, P_CKNEG = 6;

   if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
      $error("pio_ctrl: LINES must lie between 1 and 32");
   end

   logic [3:0]       reg_idx;
   logic             wr_stb;
   logic [LANES-1:0] lane_en;
   logic [BUS_W-1:0] rd_word;

   logic [LINES-1:0] plain_q [NPLAIN];
   logic [LINES-1:0] stat_q;
   logic [1:0]       ctrl_q;
   logic [LINES-1:0] pad_sync;
   logic [LINES-1:0] edge_evt;
   logic             wr_stat, wr_ctrl;

   function automatic logic [LINES-1:0] upd(input logic [LINES-1:0] cur);
      logic [BUS_W-1:0] w;
      w = '0;
      w[LINES-1:0] = cur;
      w = lane_merge(w, bus_wdat, lane_en);
      return w[LINES-1:0];
   endfunction

   function automatic logic [BUS_W-1:0] widen(input logic [LINES-1:0] v);
      logic [BUS_W-1:0] w;
      w = '0;
      w[LINES-1:0] = v;
      return w;
   endfunction

   pio_bus_slave #(
      .ADDR_W      (ADDR_W),
      .FULL_DECODE (FULL_DECODE),
      .STRICT_WORD (STRICT_WORD)
   ) u_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_cyc  (bus_cyc),
      .bus_stb  (bus_stb),
      .bus_we   (bus_we),
      .bus_adr  (bus_adr),
      .bus_sel  (bus_sel),
      .rd_word  (rd_word),
      .reg_idx  (reg_idx),
      .wr_stb   (wr_stb),
      .lane_en  (lane_en),
      .bus_rdat (bus_rdat),
      .bus_ack  (bus_ack),
      .bus_err  (bus_err)
   );

   // plain registers, one generated instance per map entry
   for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            plain_q[k] <= '0;
         end else if (wr_stb && reg_idx == PLAIN_IDX[k]) begin
            plain_q[k] <= upd(plain_q[k]);
         end
      end
   end

   assign wr_stat = wr_stb && (reg_idx == IDX_STAT);
   assign wr_ctrl = wr_stb && (reg_idx == IDX_CTRL) && lane_en[0];

   // status and control: a fresh event overrides a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         ctrl_q <= '0;
      end else begin
         stat_q <= (wr_stat ? upd(stat_q) : stat_q) | edge_evt;
         if (wr_ctrl) begin
            ctrl_q[CTRL_GLB_EN] <= bus_wdat[CTRL_GLB_EN];
         end
         ctrl_q[CTRL_PENDING] <= (wr_ctrl ? bus_wdat[CTRL_PENDING]
                                          : ctrl_q[CTRL_PENDING]) | (|edge_evt);
      end
   end

   pio_in_sync #(.LINES(LINES)) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .int_en   (plain_q[P_IEN]),
      .rise_sel (plain_q[P_POL]),
      .pad_sync (pad_sync),
      .edge_evt (edge_evt)
   );

   pio_out_drive #(.LINES(LINES)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .dout_reg (plain_q[P_DOUT]),
      .doe_reg  (plain_q[P_DOE]),
      .aux_sel  (plain_q[P_AUX]),
      .aux_in   (aux_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   always_comb begin
      rd_word = '0;
      case (reg_idx)
         IDX_PADIN:  rd_word = widen(pad_sync);
         IDX_CTRL:   rd_word[1:0] = ctrl_q;
         IDX_STAT:   rd_word = widen(stat_q);
         default: begin
            for (int k = 0; k < NPLAIN; k++) begin
               if (reg_idx == PLAIN_IDX[k]) rd_word = widen(plain_q[k]);
            end
         end
      endcase
   end

   assign extclk_sel     = plain_q[P_CKSEL];
   assign extclk_negedge = plain_q[P_CKNEG];
   assign irq            = ctrl_q[CTRL_GLB_EN] && ctrl_q[CTRL_PENDING];

   assert_stat_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_stat))
      |-> ((stat_q & ~$past(stat_q) & ~$past(plain_q[P_IEN])) == '0));

   assert_pending_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdat[CTRL_PENDING] && edge_evt == '0) |=> !irq);

   assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat && edge_evt == '0) |=> $stable(stat_q));

endmodule

// File: tb/pio_ctrl_test.sv
module pio_ctrl_test;
   localparam int LINES = 24;
   localparam int NVEC  = 21;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        cyc = 0, stb = 0, we = 0;
   logic [7:0]  adr = '0;
   logic [3:0]  sel = '0;
   logic [31:0] wdat = '0;
   logic [LINES-1:0] pad_in = '0, aux_in = '0;

   logic [31:0] rdat_f, rdat_s;
   logic ack_f, err_f, ack_s, err_s, irq_f, irq_s;
   logic [LINES-1:0] po_f, oe_f, cs_f, cn_f, po_s, oe_s, cs_s, cn_s;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   pio_ctrl #(.LINES(LINES), .FULL_DECODE(1'b1), .STRICT_WORD(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
      .bus_adr(adr), .bus_sel(sel), .bus_wdat(wdat), .bus_rdat(rdat_f),
      .bus_ack(ack_f), .bus_err(err_f), .pad_in(pad_in), .aux_in(aux_in),
      .pad_out(po_f), .pad_oe(oe_f), .extclk_sel(cs_f), .extclk_negedge(cn_f),
      .irq(irq_f));

   pio_ctrl #(.LINES(LINES), .FULL_DECODE(1'b0), .STRICT_WORD(1'b1)) uut_s (
      .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
      .bus_adr(adr), .bus_sel(sel), .bus_wdat(wdat), .bus_rdat(rdat_s),
      .bus_ack(ack_s), .bus_err(err_s), .pad_in(pad_in), .aux_in(aux_in),
      .pad_out(po_s), .pad_oe(oe_s), .extclk_sel(cs_s), .extclk_negedge(cn_s),
      .irq(irq_s));

   // {check_read, write, addr, sel, wdata, expected}
   localparam logic [77:0] VEC [NVEC] = '{
      {1'b0,1'b1,8'h04,4'hF,32'hFFA55A3C,32'h0},        // R2 data out
      {1'b1,1'b0,8'h04,4'hF,32'h0,32'h00A55A3C},        // R2 upper bits zero
      {1'b0,1'b1,8'h08,4'h2,32'h12345678,32'h0},        // R5 lane 1 only
      {1'b1,1'b0,8'h08,4'hF,32'h0,32'h00005600},
      {1'b0,1'b1,8'h08,4'h5,32'hAABBCCDD,32'h0},        // R5 lanes 0 and 2
      {1'b1,1'b0,8'h08,4'hF,32'h0,32'h00BB56DD},
      {1'b0,1'b1,8'h10,4'hF,32'h000000F0,32'h0},        // R2 polarity
      {1'b1,1'b0,8'h10,4'hF,32'h0,32'h000000F0},
      {1'b0,1'b1,8'h20,4'hF,32'h000F0F0F,32'h0},        // R2 clock select
      {1'b1,1'b0,8'h20,4'hF,32'h0,32'h000F0F0F},
      {1'b0,1'b1,8'h24,4'hF,32'h00123456,32'h0},        // R2 edge select
      {1'b1,1'b0,8'h24,4'hF,32'h0,32'h00123456},
      {1'b0,1'b1,8'h44,4'hF,32'h00FFFFFF,32'h0},        // R7 high bits set
      {1'b1,1'b0,8'h04,4'hF,32'h0,32'h00A55A3C},
      {1'b1,1'b0,8'h44,4'hF,32'h0,32'h00000000},
      {1'b0,1'b1,8'h05,4'hF,32'h00000011,32'h0},        // R7 low bits set
      {1'b1,1'b0,8'h04,4'hF,32'h0,32'h00A55A3C},
      {1'b1,1'b0,8'h28,4'hF,32'h0,32'h00000000},        // R8
      {1'b1,1'b0,8'h3C,4'hF,32'h0,32'h00000000},        // R8
      {1'b1,1'b0,8'h1C,4'hF,32'h0,32'h00000000},        // R1 status
      {1'b1,1'b0,8'h18,4'hF,32'h0,32'h00000000}         // R1 control
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one access on both instances; returns after the response edge
   task automatic access(input logic w, input logic [7:0] a, input logic [3:0] s,
                         input logic [31:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
      @(negedge clk);
      cyc = 0; stb = 0; we = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pad_out", {8'h0, po_f}, 32'h0);
      check("R1 pad_oe", {8'h0, oe_f}, 32'h0);
      check("R1 irq/ack/err", {29'h0, irq_f, ack_f, err_f}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 extclk outputs", {cs_f[15:0], cn_f[15:0]}, 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         access(VEC[v][76], VEC[v][75:68], VEC[v][67:64], VEC[v][63:32]);
         if (VEC[v][77]) begin
            check($sformatf("R2/R7/R8 vector %0d", v), rdat_f, VEC[v][31:0]);
            check($sformatf("R2 ack vector %0d", v), {31'h0, ack_f}, 32'h1);
         end
      end

      // R2 select outputs mirror registers
      check("R2 extclk_sel", {8'h0, cs_f}, 32'h000F0F0F);
      check("R2 extclk_negedge", {8'h0, cn_f}, 32'h00123456);

      // R7 partial decode aliases on the second instance
      access(0, 8'h44, 4'hF, 0);
      check("R7 alias read", rdat_s, 32'h00000011);

      // R6 strict-word refusal; R5 lane write on the non-strict instance
      access(1, 8'h04, 4'h1, 32'h000000FF);
      check("R6 err", {30'h0, ack_s, err_s}, 32'h1);
      check("R5 ack", {30'h0, ack_f, err_f}, 32'h2);
      access(0, 8'h04, 4'hF, 0);
      check("R6 no write", rdat_s, 32'h00000011);
      check("R5 lane0 write", rdat_f, 32'h00A55AFF);

      // R4 pad drive
      @(negedge clk);
      check("R4 pad_out", {8'h0, po_f}, 32'h00A55AFF);
      check("R4 pad_oe", {8'h0, oe_f}, 32'h00BB56DD);
      aux_in = 24'hFFFFF0;
      access(1, 8'h14, 4'hF, 32'h0000000F);
      repeat (2) @(negedge clk);
      check("R4 aux mux", {8'h0, po_f}, 32'h00A55AF0);

      // R3 two-flop delay and read-only input
      pad_in = 24'h5A5A5A;
      access(0, 8'h00, 4'hF, 0);
      check("R3 old value", rdat_f, 32'h0);
      repeat (3) @(negedge clk);
      access(1, 8'h00, 4'hF, 32'h00FFFFFF);
      access(0, 8'h00, 4'hF, 0);
      check("R3 synced value", rdat_f, 32'h005A5A5A);

      // R9 interrupts: lines 0 (falling) and 4 (rising) enabled
      pad_in = '0;
      repeat (5) @(negedge clk);
      access(1, 8'h1C, 4'hF, 0);
      access(1, 8'h18, 4'hF, 0);
      access(1, 8'h0C, 4'hF, 32'h00000011);
      access(1, 8'h18, 4'hF, 32'h00000001);
      pad_in = 24'h000013;                     // rises on 0,1,4
      repeat (5) @(negedge clk);
      access(0, 8'h1C, 4'hF, 0);
      check("R9 rising only line4", rdat_f, 32'h00000010);
      access(0, 8'h18, 4'hF, 0);
      check("R9 ctrl pending", rdat_f, 32'h00000003);
      check("R9 irq high", {31'h0, irq_f}, 32'h1);
      pad_in = 24'h000012;                     // falls on 0
      repeat (5) @(negedge clk);
      pad_in = 24'h000002;                     // falls on 4 (rising polarity)
      repeat (5) @(negedge clk);
      access(0, 8'h1C, 4'hF, 0);
      check("R9 falling line0", rdat_f, 32'h00000011);

      // R10 clearing
      access(1, 8'h1C, 4'hF, 32'h00000001);
      access(0, 8'h1C, 4'hF, 0);
      check("R10 status clear", rdat_f, 32'h00000001);
      access(1, 8'h18, 4'hF, 32'h00000001);
      @(negedge clk);
      check("R10 irq cleared", {31'h0, irq_f}, 32'h0);
      access(0, 8'h18, 4'hF, 0);
      check("R10 ctrl", rdat_f, 32'h00000001);

      // R9 global enable off: pending sets, irq stays low
      access(1, 8'h18, 4'hF, 0);
      pad_in = 24'h000012;
      repeat (5) @(negedge clk);
      access(0, 8'h18, 4'hF, 0);
      check("R9 pending without enable", rdat_f, 32'h00000002);
      check("R9 irq gated", {31'h0, irq_f}, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule